// File: doc/BRIEF.md
# Object Handle Hash Lookup

This block turns a 32-bit object handle into an object descriptor. It folds the handle into a table index and mixes in the requesting channel. It then fetches one 8-byte entry from a hash table held in ordinary memory and decodes that entry into an instance address, an engine number and an owning channel. A command front end issues one lookup at a time with a start pulse and waits for the done strobe. The strobe carries exactly one of three outcomes: hit, miss or error.

The table size is given by a small size code, and the table is placed by a base field in 4 KiB units. The block reads the table through a plain synchronous read port: it presents an address with a read enable, and the word comes back on the following cycle. When a handle maps outside the table, the block flags an error and does not touch memory. When the stored handle differs from the requested one, or the entry is not marked valid, the block reports a miss and returns no descriptor.

Top module: `ohl_lookup`

## Requirements
- R1: While reset is held and after it is released, done, busy, hit, miss, err and memRdEn are all 0.
- R2: The table holds 2^(12+sizeCode) bytes. The chunk width is w = 11+sizeCode. The index starts at zero and takes the XOR of each successive w-bit chunk of the handle, from the low end upward, until no set bits remain.
- R3: After folding, chanId shifted left by (w-4) is XORed into the index.
- R4: A lookup reads two 32-bit words. The first read is at word address ((tblBase<<12) + index*8)/4 and gives the stored handle. The second read, on the next cycle, is at that address plus 1 and gives the context word.
- R5: If index*8 is not below the table size in bytes, the lookup ends with err=1, hit=0 and miss=0. No memory read takes place.
- R6: On a hit, instAddr is context[15:0] shifted left by 4, engine is context[17:16] and entryChan is context[28:24].
- R7: Context bit 31 is the valid flag. If the stored handle differs from the requested handle, or the valid flag is clear, the lookup ends with miss=1, hit=0, and instAddr, engine and entryChan all 0. With done high, exactly one of hit, miss and err is 1.
- R8: Let k be max(1, ceil(bit length of handle / w)). done rises k+3 clock edges after the edge that accepts start on a lookup that reads memory, and k edges after it on an error.
- R9: start and the other request inputs are ignored while busy is high. The result is that of the accepted request.
- R10: done is high for exactly one cycle per lookup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request a lookup (taken when not busy) |
| handle | input | 32 | Object handle to translate |
| chanId | input | 5 | Requesting channel |
| sizeCode | input | 2 | Table size code |
| tblBase | input | 4 | Table base in 4 KiB units |
| memRdEn | output | 1 | Memory read request |
| memAddr | output | 15 | Memory word address |
| memRdData | input | 32 | Read word, valid the cycle after the request |
| busy | output | 1 | Lookup in progress |
| done | output | 1 | One-cycle completion strobe |
| hit | output | 1 | Descriptor returned |
| miss | output | 1 | Tag mismatch or invalid entry |
| err | output | 1 | Index outside the table |
| instAddr | output | 20 | Instance address |
| engine | output | 2 | Engine number |
| entryChan | output | 5 | Channel stored in the entry |

## Verification
The bench works out, for each request, how many fold cycles the handle needs. It then expects done exactly k+3 edges after the accepting edge on a memory lookup, and k edges after it on an error. It counts edges from that accepting edge and compares the count it sees. The outputs are sampled on the falling clock edge, half a cycle after the edge that updates them. Read addresses are logged at the memory model when the requests are made, because the read data is only needed one cycle later. The descriptor fields are checked in the single cycle that done is high, and the cycle after is checked to confirm that done has fallen.

// File: rtl/ohl_pkg.sv
package ohl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FOLD,
    ST_READ_LO,
    ST_READ_HI,
    ST_DONE
  } ohlState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic load;       // latch request
    logic foldStep;   // fold one chunk
    logic issueLo;    // read stored-handle word
    logic issueHi;    // read context word
    logic captureLo;  // keep stored handle
    logic finish;     // decode context, report
    logic finishErr;  // report out-of-table index
  } ohlStrobe_t;

endpackage

// File: rtl/ohl_ctrl.sv
module ohl_ctrl
  import ohl_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       foldLast,
  input  logic       rangeBad,
  output ohlStrobe_t stb,
  output logic       busy
);

  ohlState_e stateQ, stateNxt;

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateNxt;
  end

  always_comb begin
    stb      = '0;
    stateNxt = stateQ;
    unique case (stateQ)
      ST_IDLE: begin
        if (start) begin
          stb.load = 1'b1;
          stateNxt = ST_FOLD;
        end
      end
      ST_FOLD: begin
        stb.foldStep = 1'b1;
        if (foldLast) begin
          if (rangeBad) begin
            stb.finishErr = 1'b1;
            stateNxt      = ST_IDLE;
          end else begin
            stateNxt = ST_READ_LO;
          end
        end
      end
      ST_READ_LO: begin
        stb.issueLo = 1'b1;
        stateNxt    = ST_READ_HI;
      end
      ST_READ_HI: begin
        stb.issueHi   = 1'b1;
        stb.captureLo = 1'b1;
        stateNxt      = ST_DONE;
      end
      ST_DONE: begin
        stb.finish = 1'b1;
        stateNxt   = ST_IDLE;
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  assign busy = (stateQ != ST_IDLE);

  // R9: once a lookup runs it stays busy until it reports
  p_busy_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !stb.finish && !stb.finishErr) |=> busy);

  // R4: the context read always follows the handle read
  p_read_order_r4: assert property (@(posedge clk) disable iff (!rstN)
    stb.issueLo |=> (stb.issueHi && stb.captureLo));

endmodule

// File: rtl/ohl_datapath.sv
module ohl_datapath
  import ohl_pkg::*;
#(
  parameter int HANDLE_W  = 32,
  parameter int CHAN_W    = 5,
  parameter int CODE_W    = 2,
  parameter int BASE_W    = 4,
  parameter int MIN_LOG2  = 12,
  parameter int HASH_W    = 14,
  parameter int WORD_AW   = 15,
  parameter int INST_W    = 16,
  parameter int INST_SH   = 4,
  parameter int ENG_W     = 2,
  parameter int ENG_LSB   = 16,
  parameter int CHAN_LSB  = 24,
  parameter int VALID_BIT = 31
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  ohlStrobe_t                  stb,
  input  logic [HANDLE_W-1:0]         handle,
  input  logic [CHAN_W-1:0]           chanId,
  input  logic [CODE_W-1:0]           sizeCode,
  input  logic [BASE_W-1:0]           tblBase,
  input  logic [HANDLE_W-1:0]         memRdData,
  output logic                        foldLast,
  output logic                        rangeBad,
  output logic                        memRdEn,
  output logic [WORD_AW-1:0]          memAddr,
  output logic                        done,
  output logic                        hit,
  output logic                        miss,
  output logic                        err,
  output logic [INST_W+INST_SH-1:0]   instAddr,
  output logic [ENG_W-1:0]            engine,
  output logic [CHAN_W-1:0]           entryChan
);

  localparam int SHW      = $clog2(HANDLE_W + 1);
  localparam int MIX_W    = HASH_W + CHAN_W;
  localparam int LIM_BASE = MIN_LOG2 - 3;   // index*8 < 2^log2
  localparam int WORD_SH  = MIN_LOG2 - 2;   // base in words

  logic [HANDLE_W-1:0] handleQ, remQ, loQ;
  logic [HASH_W-1:0]   hashQ;
  logic [CODE_W-1:0]   codeQ;
  logic [CHAN_W-1:0]   chanQ;
  logic [BASE_W-1:0]   baseQ;
  logic [WORD_AW-1:0]  idxQ;
  logic [MIX_W-1:0]    finalHashQ;

  logic [SHW-1:0]      chunkW;
  logic [HANDLE_W-1:0] chunkMask, nextRem;
  logic [HASH_W-1:0]   foldedHash;
  logic [MIX_W-1:0]    mixedHash;
  logic [WORD_AW-1:0]  wordIdx;
  logic                tagOk, hitNow;

  // ---- fold step, channel mix and range ----
  always_comb begin
    chunkW     = SHW'(MIN_LOG2 - 1) + SHW'(codeQ);
    chunkMask  = (HANDLE_W'(1) << chunkW) - HANDLE_W'(1);
    foldedHash = hashQ ^ HASH_W'(remQ & chunkMask);
    nextRem    = remQ >> chunkW;
    foldLast   = (nextRem == '0);
    mixedHash  = MIX_W'(foldedHash) ^ (MIX_W'(chanQ) << (chunkW - SHW'(4)));
    rangeBad   = ((mixedHash >> (LIM_BASE + int'(codeQ))) != '0);
    wordIdx    = (WORD_AW'(baseQ) << WORD_SH)
               + (WORD_AW'(mixedHash[HASH_W-1:0]) << 1);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      handleQ    <= '0;
      remQ       <= '0;
      hashQ      <= '0;
      codeQ      <= '0;
      chanQ      <= '0;
      baseQ      <= '0;
      idxQ       <= '0;
      finalHashQ <= '0;
    end else if (stb.load) begin
      handleQ <= handle;
      remQ    <= handle;
      hashQ   <= '0;
      codeQ   <= sizeCode;
      chanQ   <= chanId;
      baseQ   <= tblBase;
    end else if (stb.foldStep) begin
      remQ       <= nextRem;
      hashQ      <= foldedHash;
      idxQ       <= wordIdx;
      finalHashQ <= mixedHash;
    end
  end

  // ---- memory port ----
  assign memRdEn = stb.issueLo | stb.issueHi;
  assign memAddr = stb.issueHi ? idxQ + WORD_AW'(1) : idxQ;

  always_ff @(posedge clk) begin
    if (!rstN)              loQ <= '0;
    else if (stb.captureLo) loQ <= memRdData;
  end

  // ---- decode and report ----
  assign tagOk  = (loQ == handleQ);
  assign hitNow = tagOk && memRdData[VALID_BIT];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      done      <= 1'b0;
      hit       <= 1'b0;
      miss      <= 1'b0;
      err       <= 1'b0;
      instAddr  <= '0;
      engine    <= '0;
      entryChan <= '0;
    end else begin
      done <= stb.finish | stb.finishErr;
      if (stb.finishErr) begin
        hit       <= 1'b0;
        miss      <= 1'b0;
        err       <= 1'b1;
        instAddr  <= '0;
        engine    <= '0;
        entryChan <= '0;
      end else if (stb.finish) begin
        hit       <= hitNow;
        miss      <= !hitNow;
        err       <= 1'b0;
        instAddr  <= hitNow ? {memRdData[INST_W-1:0], INST_SH'(0)} : '0;
        engine    <= hitNow ? memRdData[ENG_LSB +: ENG_W] : '0;
        entryChan <= hitNow ? memRdData[CHAN_LSB +: CHAN_W] : '0;
      end
    end
  end

  // R10: completion strobe lasts one cycle
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R7: exactly one outcome flag accompanies done
  p_one_outcome_r7: assert property (@(posedge clk) disable iff (!rstN)
    done |-> ($countones({hit, miss, err}) == 1));

  // R5: memory is only read for an index inside the table
  p_in_range_r5: assert property (@(posedge clk) disable iff (!rstN)
    stb.issueLo |-> ((finalHashQ >> (LIM_BASE + int'(codeQ))) == '0));

endmodule

// File: rtl/ohl_lookup.sv
module ohl_lookup
  import ohl_pkg::*;
#(
  parameter int HANDLE_W  = 32,
  parameter int CHAN_W    = 5,
  parameter int CODE_W    = 2,
  parameter int BASE_W    = 4,
  parameter int MIN_LOG2  = 12,
  parameter int INST_W    = 16,
  parameter int INST_SH   = 4,
  parameter int ENG_W     = 2,
  parameter int ENG_LSB   = 16,
  parameter int CHAN_LSB  = 24,
  parameter int VALID_BIT = 31,
  localparam int MAX_LOG2 = MIN_LOG2 + (1 << CODE_W) - 1,
  localparam int HASH_W   = MAX_LOG2 - 1,
  localparam int TOP_A    = BASE_W + MIN_LOG2,
  localparam int BYTE_AW  = ((TOP_A > MAX_LOG2) ? TOP_A : MAX_LOG2) + 1,
  localparam int WORD_AW  = BYTE_AW - 2
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      start,
  input  logic [HANDLE_W-1:0]       handle,
  input  logic [CHAN_W-1:0]         chanId,
  input  logic [CODE_W-1:0]         sizeCode,
  input  logic [BASE_W-1:0]         tblBase,
  output logic                      memRdEn,
  output logic [WORD_AW-1:0]        memAddr,
  input  logic [HANDLE_W-1:0]       memRdData,
  output logic                      busy,
  output logic                      done,
  output logic                      hit,
  output logic                      miss,
  output logic                      err,
  output logic [INST_W+INST_SH-1:0] instAddr,
  output logic [ENG_W-1:0]          engine,
  output logic [CHAN_W-1:0]         entryChan
);

  ohlStrobe_t stb;
  logic       foldLast, rangeBad;

  ohl_ctrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .foldLast (foldLast),
    .rangeBad (rangeBad),
    .stb      (stb),
    .busy     (busy)
  );

  ohl_datapath #(
    .HANDLE_W (HANDLE_W),  .CHAN_W   (CHAN_W),   .CODE_W   (CODE_W),
    .BASE_W   (BASE_W),    .MIN_LOG2 (MIN_LOG2), .HASH_W   (HASH_W),
    .WORD_AW  (WORD_AW),   .INST_W   (INST_W),   .INST_SH  (INST_SH),
    .ENG_W    (ENG_W),     .ENG_LSB  (ENG_LSB),  .CHAN_LSB (CHAN_LSB),
    .VALID_BIT(VALID_BIT)
  ) uData (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .handle    (handle),
    .chanId    (chanId),
    .sizeCode  (sizeCode),
    .tblBase   (tblBase),
    .memRdData (memRdData),
    .foldLast  (foldLast),
    .rangeBad  (rangeBad),
    .memRdEn   (memRdEn),
    .memAddr   (memAddr),
    .done      (done),
    .hit       (hit),
    .miss      (miss),
    .err       (err),
    .instAddr  (instAddr),
    .engine    (engine),
    .entryChan (entryChan)
  );

  // R4: the second read of a pair addresses the next word
  p_read_pair_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memRdEn) |=> (memRdEn && (memAddr == $past(memAddr) + WORD_AW'(1))));

  // R5: an error result is never preceded by a read
  p_err_no_read_r5: assert property (@(posedge clk) disable iff (!rstN)
    (done && err) |-> !$past(memRdEn));

endmodule

// File: tb/tb_ohl_lookup.sv
module tb_ohl_lookup;

  localparam int NV = 10;
  // kind: 0 = stored entry matches, 1 = stored handle differs, 2 = valid bit clear
  localparam logic [31:0] V_HANDLE [NV] = '{32'h0000_0005, 32'h0008_2900, 32'h0000_0007,
    32'h0000_0010, 32'hFFFF_FFFF, 32'h0000_0009, 32'h0000_000A, 32'h0000_0000,
    32'h0000_0000, 32'h3000_0005};
  localparam logic [4:0]  V_CHAN [NV] = '{5'd0, 5'd1, 5'd3, 5'd4, 5'd0, 5'd2, 5'd0, 5'd5, 5'd0, 5'd1};
  localparam logic [1:0]  V_CODE [NV] = '{2'd0, 2'd0, 2'd1, 2'd0, 2'd0, 2'd2, 2'd3, 2'd0, 2'd2, 2'd3};
  localparam logic [3:0]  V_BASE [NV] = '{4'd1, 4'd2, 4'd3, 4'd7, 4'd8, 4'd4, 4'd5, 4'd9, 4'd15, 4'd6};
  localparam int          V_KIND [NV] = '{0, 0, 0, 0, 0, 1, 2, 0, 0, 0};
  localparam logic [31:0] V_CTX  [NV] = '{32'h8001_1234, 32'h8102_0ABC, 32'h8300_FFFF,
    32'h8000_0000, 32'h8000_0000, 32'h8000_0001, 32'h0001_0002, 32'h8000_0000,
    32'h9F03_0001, 32'h8102_0010};

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [31:0] handle = '0;
  logic [4:0]  chanId = '0;
  logic [1:0]  sizeCode = '0;
  logic [3:0]  tblBase = '0;
  logic        memRdEn;
  logic [14:0] memAddr;
  logic [31:0] memRdData = '0;
  logic        busy, done, hit, miss, err;
  logic [19:0] instAddr;
  logic [1:0]  engine;
  logic [4:0]  entryChan;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  int rdTotal = 0;
  logic        prevEn = 1'b0;
  logic [14:0] firstAddr = '0, secondAddr = '0;
  logic [31:0] mem [int unsigned];

  always #2 clk = ~clk;   // 250 MHz

  ohl_lookup dut (
    .clk(clk), .rstN(rstN), .start(start), .handle(handle), .chanId(chanId),
    .sizeCode(sizeCode), .tblBase(tblBase), .memRdEn(memRdEn), .memAddr(memAddr),
    .memRdData(memRdData), .busy(busy), .done(done), .hit(hit), .miss(miss),
    .err(err), .instAddr(instAddr), .engine(engine), .entryChan(entryChan)
  );

  // synchronous memory model with read-address log
  always @(posedge clk) begin
    if (memRdEn) begin
      memRdData <= mem.exists(int'(memAddr)) ? mem[int'(memAddr)] : 32'hDEAD_BEEF;
      rdTotal   <= rdTotal + 1;
      if (!prevEn) firstAddr  <= memAddr;
      else         secondAddr <= memAddr;
    end
    prevEn <= memRdEn;
  end

  task automatic finishRun();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      fails = fails + 1;
      $display("FAIL watchdog: actual %0d cycles, expected under 100000", cycles);
      finishRun();
    end
  end

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      fails = fails + 1;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  function automatic int unsigned refHash(input logic [31:0] h, input logic [4:0] c,
                                          input logic [1:0] code);
    int unsigned w = 11 + int'(code);
    int unsigned acc = 0;
    int unsigned x = h;
    while (x != 0) begin
      acc = acc ^ (x & ((32'd1 << w) - 1));
      x = x >> w;
    end
    return acc ^ (int'(c) << (w - 4));
  endfunction

  function automatic int refFolds(input logic [31:0] h, input logic [1:0] code);
    int unsigned w = 11 + int'(code);
    int unsigned x = h;
    int k = 0;
    do begin
      x = x >> w;
      k++;
    end while (x != 0);
    return k;
  endfunction

  // issue one request, hold start for extra cycles with decoy inputs, return latency
  task automatic runLookup(input int v, input int holdExtra, output int lat);
    @(negedge clk);
    handle = V_HANDLE[v]; chanId = V_CHAN[v]; sizeCode = V_CODE[v]; tblBase = V_BASE[v];
    start = 1'b1;
    @(negedge clk);
    lat = 1;
    handle = ~V_HANDLE[v]; chanId = V_CHAN[v] + 5'd1; tblBase = V_BASE[v] + 4'd1;
    start = (holdExtra > 0);
    while (!done && lat < 60) begin
      @(negedge clk);
      lat++;
      if (lat > holdExtra) start = 1'b0;
    end
    start = 1'b0;
    if (!done) lat = 0;
    else lat = lat - 1;  // edges after the accepting edge
  endtask

  task automatic doVector(input int v, input int holdExtra, input string tag);
    int unsigned h, size, expLo;
    int k, lat, rd0, expLat;
    logic expErr, expHit;
    h      = refHash(V_HANDLE[v], V_CHAN[v], V_CODE[v]);
    size   = 32'd1 << (12 + int'(V_CODE[v]));
    expErr = !(h * 8 < size);
    expLo  = ((int'(V_BASE[v]) << 12) + h * 8) >> 2;
    expHit = !expErr && V_KIND[v] == 0 && V_CTX[v][31];
    if (!expErr) begin
      mem[expLo]     = (V_KIND[v] == 1) ? (V_HANDLE[v] ^ 32'h8000_0000) : V_HANDLE[v];
      mem[expLo + 1] = (V_KIND[v] == 2) ? {1'b0, V_CTX[v][30:0]} : V_CTX[v];
    end
    k      = refFolds(V_HANDLE[v], V_CODE[v]);
    expLat = expErr ? k : k + 3;
    rd0    = rdTotal;
    runLookup(v, holdExtra, lat);
    chk("R8", {tag, " latency"}, lat, expLat);
    chk("R5", {tag, " err"}, {31'd0, err}, {31'd0, expErr});
    chk("R7", {tag, " miss"}, {31'd0, miss}, {31'd0, !expErr && !expHit});
    chk("R6", {tag, " hit"}, {31'd0, hit}, {31'd0, expHit});
    chk("R6", {tag, " instAddr"}, {12'd0, instAddr}, expHit ? {12'd0, V_CTX[v][15:0], 4'h0} : 32'd0);
    chk("R6", {tag, " engine"}, {30'd0, engine}, expHit ? {30'd0, V_CTX[v][17:16]} : 32'd0);
    chk("R6", {tag, " entryChan"}, {27'd0, entryChan}, expHit ? {27'd0, V_CTX[v][28:24]} : 32'd0);
    if (expErr) begin
      chk("R5", {tag, " no reads"}, rdTotal - rd0, 0);
    end else begin
      chk("R4", {tag, " read count"}, rdTotal - rd0, 2);
      chk("R2", {tag, " R3 hashed lo addr"}, {17'd0, firstAddr}, expLo);
      chk("R4", {tag, " hi addr"}, {17'd0, secondAddr}, expLo + 1);
    end
    @(negedge clk);
    chk("R10", {tag, " done falls"}, {31'd0, done}, 32'd0);
  endtask

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1", "outputs in reset", {26'd0, done, busy, hit, miss, err, memRdEn}, 32'd0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1", "outputs after reset", {26'd0, done, busy, hit, miss, err, memRdEn}, 32'd0);

    // table walk
    for (int v = 0; v < NV; v++) begin
      doVector(v, 0, $sformatf("vec%0d", v));
    end

    // R9: start held with decoy inputs while busy
    doVector(1, 3, "r9_busy_hold");
    doVector(9, 2, "r9_busy_hold_long");

    // back-to-back: error lookup right after a hit
    doVector(3, 0, "err_after_hit");
    doVector(0, 0, "hit_after_err");

    finishRun();
  end

endmodule